// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the bus-facing half of a serial memory that sits on a two-wire I2C bus as a target. The clock and data lines come in asynchronously and are resampled by a faster system clock. From the resampled lines the block recognises the opening and closing bus conditions. It also recognises the byte framing and the acknowledge slot. The array itself sits outside, behind a narrow port: an address, a write-data byte with a one-cycle write strobe, and a read-data byte. Read data is expected to follow the address within a few system clocks.

A command begins with a select byte. The block answers only when that byte carries the memory type code and the three chip-enable bits match its strap inputs. A write command then carries the address bytes and any number of data bytes. Each data byte goes to the array port, and the address steps forward after it. A read command streams bytes out from the current address. The closing STOP of a write command that carried data raises a one-cycle commit pulse, which starts the slow programming of the array. The data line is driven only as an open-drain pull-down enable.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the SDA pull-down enable, the write strobe and the commit pulse are all low. Any clocking of bytes before the first START is ignored, and no acknowledge is given.
- R2: The SDA pull-down enable changes only while the resampled SCL is low. Incoming data bits are taken on SCL rising edges.
- R3: A START is SDA falling while SCL is high. It is honoured at any point, including mid-command. It restarts select-byte reception and discards any commit still pending from a write in progress.
- R4: The select byte arrives MSB first. Bits 7..4 must equal 1010, bit 3 must match chip_en_i[2], bit 2 chip_en_i[1] and bit 1 chip_en_i[0]. Bit 0 set means read. On a match the block pulls SDA low during the ninth SCL pulse; on a mismatch it stays silent until the next START.
- R5: A write command carries ADDR_W/8 address bytes (rounded up), high byte first. Each one is acknowledged.
- R6: Each data byte of a write is acknowledged and appears as a one-cycle mem_we_o at the current address. The address then increments, carrying across byte boundaries.
- R7: A STOP (SDA rising while SCL is high) that ends a write command which carried at least one data byte raises commit_o for exactly one cycle. A command with no data byte, a read, or one cut short by a START commits nothing.
- R8: A read command drives the byte at the current address MSB first and releases SDA for the ninth pulse.
- R9: A master acknowledge (SDA low on the ninth pulse) advances the address and starts the next byte. A NoAck leaves the address unchanged and releases SDA. After the following STOP, bytes are ignored until a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| chip_en_i | input | 3 | Chip-enable straps compared with select bits 3..1 |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| mem_addr_o | output | ADDR_W | Current array address |
| mem_wdata_o | output | 8 | Byte to write into the array |
| mem_we_o | output | 1 | One-cycle write strobe for mem_wdata_o at mem_addr_o |
| mem_rdata_i | input | 8 | Array byte at mem_addr_o |
| commit_o | output | 1 | One-cycle pulse starting the array write cycle |

## Verification
A wrong phase or bit count shows up first in the acknowledge slot: a missing or extra pull-down on the ninth pulse of the very byte where the count slipped. A corrupted address shows up either at the next array strobe or in the first bit of the next byte read back, within one byte time. A stale write flag shows up as an extra or missing commit pulse a few system clocks after the STOP. The bench keeps its own model of the array contents and of the expected strobes, and compares them against the ports on every clock.

// File: rtl/smt_pkg.sv
`timescale 1ns/1ps
package smt_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SEL   = 3'd1,
      PH_ADDR  = 3'd2,
      PH_WDATA = 3'd3,
      PH_RDATA = 3'd4
   } phase_e;

   localparam int BYTE_W    = 8;
   localparam int ACK_SLOT  = 8;
   localparam int ACK_DONE  = 9;
endpackage

// File: rtl/smt_line_sync.sv
`timescale 1ns/1ps
module smt_line_sync #(
   parameter int   WIDTH   = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smt_line_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {WIDTH{RST_VAL}};
            else        q <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {WIDTH{RST_VAL}};
            else        q <= g_stage[s-1].q;
         end
      end
   end

   assign dout = g_stage[STAGES-1].q;
endmodule

// File: rtl/smt_bus_events.sv
`timescale 1ns/1ps
module smt_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/serial_mem_target.sv
`timescale 1ns/1ps
module serial_mem_target
   import smt_pkg::*;
#(
   parameter int         ADDR_W      = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [2:0]        chip_en_i,
   output logic              sda_oe_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   output logic              mem_we_o,
   input  logic [7:0]        mem_rdata_i,
   output logic              commit_o
);
   localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
   localparam int ABC_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [ABC_W-1:0] ABC_LAST = ABC_W'(ADDR_BYTES - 1);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("serial_mem_target: ADDR_W must lie in 8..32");
   end

   logic [1:0] sync_q;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_c, stop_c;

   smt_line_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({scl_i, sda_i}),
      .dout (sync_q)
   );

   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   smt_bus_events u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s   (scl_s),
      .sda_s   (sda_s),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_c (start_c),
      .stop_c  (stop_c)
   );

   phase_e            phase_q;
   logic [3:0]        bitcnt_q;
   logic [7:0]        rx_q;
   logic [6:0]        tx_q;
   logic              tx_byte_q;
   logic              m_nack_q;
   logic [ABC_W-1:0]  abyte_q;
   logic [ADDR_W-1:0] addr_q;
   logic              adv_q;
   logic              wrote_q;
   logic              oe_q;
   logic              we_q;
   logic [7:0]        wdata_q;
   logic              commit_q;
   logic              sel_hit;
   logic              listening;

   assign sel_hit   = (rx_q[7:4] == TYPE_CODE) && (rx_q[3:1] == chip_en_i);
   assign listening = (phase_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         bitcnt_q  <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         tx_byte_q <= 1'b0;
         m_nack_q  <= 1'b0;
         abyte_q   <= '0;
         addr_q    <= '0;
         adv_q     <= 1'b0;
         wrote_q   <= 1'b0;
         oe_q      <= 1'b0;
         we_q      <= 1'b0;
         wdata_q   <= '0;
         commit_q  <= 1'b0;
      end else begin
         we_q     <= 1'b0;
         commit_q <= 1'b0;
         if (start_c) begin
            phase_q   <= PH_SEL;
            bitcnt_q  <= '0;
            oe_q      <= 1'b0;
            wrote_q   <= 1'b0;
            tx_byte_q <= 1'b0;
            adv_q     <= 1'b0;
         end else if (stop_c) begin
            phase_q   <= PH_IDLE;
            bitcnt_q  <= '0;
            oe_q      <= 1'b0;
            commit_q  <= wrote_q;
            wrote_q   <= 1'b0;
            tx_byte_q <= 1'b0;
            adv_q     <= 1'b0;
         end else if (phase_q != PH_IDLE) begin
            if (scl_rise) begin
               if (bitcnt_q < 4'(ACK_SLOT)) begin
                  rx_q     <= {rx_q[6:0], sda_s};
                  bitcnt_q <= bitcnt_q + 4'd1;
               end else if (bitcnt_q == 4'(ACK_SLOT)) begin
                  bitcnt_q <= 4'(ACK_DONE);
                  if (tx_byte_q) begin
                     m_nack_q <= sda_s;
                     if (!sda_s) addr_q <= addr_q + ADDR_W'(1);
                  end
               end
            end else if (scl_fall) begin
               if (tx_byte_q && bitcnt_q >= 4'd1 && bitcnt_q < 4'(ACK_SLOT)) begin
                  oe_q <= ~tx_q[6];
                  tx_q <= {tx_q[5:0], 1'b0};
               end else if (bitcnt_q == 4'(ACK_SLOT)) begin
                  oe_q <= 1'b0;
                  case (phase_q)
                     PH_SEL: begin
                        if (sel_hit) begin
                           oe_q     <= 1'b1;
                           m_nack_q <= 1'b0;
                           abyte_q  <= '0;
                           phase_q  <= rx_q[0] ? PH_RDATA : PH_ADDR;
                        end else begin
                           phase_q  <= PH_IDLE;
                        end
                     end
                     PH_ADDR: begin
                        oe_q   <= 1'b1;
                        addr_q <= ADDR_W'({addr_q, rx_q});
                        if (abyte_q == ABC_LAST) phase_q <= PH_WDATA;
                        else                     abyte_q <= abyte_q + ABC_W'(1);
                     end
                     PH_WDATA: begin
                        oe_q    <= 1'b1;
                        we_q    <= 1'b1;
                        wdata_q <= rx_q;
                        wrote_q <= 1'b1;
                        adv_q   <= 1'b1;
                     end
                     default: oe_q <= 1'b0;
                  endcase
               end else if (bitcnt_q == 4'(ACK_DONE)) begin
                  bitcnt_q <= '0;
                  oe_q     <= 1'b0;
                  if (adv_q) begin
                     addr_q <= addr_q + ADDR_W'(1);
                     adv_q  <= 1'b0;
                  end
                  if (phase_q == PH_RDATA) begin
                     if (tx_byte_q && m_nack_q) begin
                        phase_q   <= PH_IDLE;
                        tx_byte_q <= 1'b0;
                     end else begin
                        tx_byte_q <= 1'b1;
                        tx_q      <= mem_rdata_i[6:0];
                        oe_q      <= ~mem_rdata_i[7];
                     end
                  end
               end
            end
         end
      end
   end

   assign sda_oe_o    = oe_q;
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = wdata_q;
   assign mem_we_o    = we_q;
   assign commit_o    = commit_q;
endmodule

// File: rtl/smt_checker.sv
`timescale 1ns/1ps
module smt_checker #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              stop_c,
   input logic              listening,
   input logic              sda_oe_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              commit_o
);
   // R1: while waiting for a START the line is never pulled
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      listening |-> !sda_oe_o);

   // R2: pull-down enable only moves while SCL is low
   a_r2_oe_hold_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

   // R6: write strobe lasts one cycle and the address holds right after it
   a_r6_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o);

   a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> $stable(mem_addr_o));

   // R7: commit is a single-cycle pulse that follows a STOP
   a_r7_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o);

   a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> $past(stop_c));
endmodule

bind serial_mem_target smt_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .stop_c    (stop_c),
   .listening (listening),
   .sda_oe_o  (sda_oe_o),
   .mem_we_o  (mem_we_o),
   .mem_addr_o(mem_addr_o),
   .commit_o  (commit_o)
);

// File: tb/serial_mem_target_tb_top.sv
`timescale 1ns/1ps
module serial_mem_target_tb_top;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl = 1'b1;
   logic          sda_m = 1'b1;
   logic [2:0]    ce = 3'b101;
   logic          sda_oe;
   logic          sda_line;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic          mem_we;
   logic [7:0]    mem_rdata = 8'hFF;
   logic          commit;

   int n_chk = 0;
   int n_err = 0;
   int n_commit = 0;
   int exp_q[$];
   logic [7:0] bram [int];
   bit finished = 1'b0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   serial_mem_target #(.ADDR_W(AW)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_line),
      .chip_en_i  (ce),
      .sda_oe_o   (sda_oe),
      .mem_addr_o (mem_addr),
      .mem_wdata_o(mem_wdata),
      .mem_we_o   (mem_we),
      .mem_rdata_i(mem_rdata),
      .commit_o   (commit)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // behavioural array plus per-clock comparison with the reference queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            bram[int'(mem_addr)] = mem_wdata;
            if (exp_q.size() == 0) begin
               chk("R6 unexpected strobe", int'(mem_addr), -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk("R6 strobe addr/data", (int'(mem_addr) << 8) | int'(mem_wdata), e);
            end
         end
         if (commit) n_commit++;
      end
      mem_rdata = bram.exists(int'(mem_addr)) ? bram[int'(mem_addr)] : 8'hFF;
   end

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      if (!scl) begin
         w(4); sda_m = 1'b1; w(4); scl = 1'b1; w(8);
      end else begin
         sda_m = 1'b1; w(8);
      end
      sda_m = 1'b0; w(8); scl = 1'b0;
   endtask

   task automatic bus_stop();
      w(4); sda_m = 1'b0; w(4); scl = 1'b1; w(8); sda_m = 1'b1; w(8);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         w(4); sda_m = b[i]; w(4); scl = 1'b1; w(8); scl = 1'b0;
      end
      w(4); sda_m = 1'b1; w(4); scl = 1'b1; w(4);
      acked = ~sda_line;
      w(4); scl = 1'b0;
   endtask

   task automatic read_byte(input bit mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         w(4); sda_m = 1'b1; w(4); scl = 1'b1; w(4);
         d[i] = sda_line;
         w(4); scl = 1'b0;
      end
      w(4); sda_m = ~mack; w(4); scl = 1'b1; w(8); scl = 1'b0;
   endtask

   task automatic wr_data(input int addr, input logic [7:0] d, input string req);
      bit a;
      exp_q.push_back((addr << 8) | int'(d));
      send_byte(d, a);
      chk(req, int'(a), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      bit a;
      logic [7:0] d;
      w(5);
      rst_n = 1'b1;
      w(5);
      // R1 reset state
      chk("R1 oe after reset", int'(sda_oe), 0);
      chk("R1 we after reset", int'(mem_we), 0);
      chk("R1 commit after reset", int'(commit), 0);

      // R1 matching select byte without START is ignored
      send_byte(8'hAA, a);
      chk("R1 no ack before START", int'(a), 0);
      bus_stop();

      // R4 wrong type code, then wrong chip enable
      bus_start(); send_byte(8'hBA, a); chk("R4 type mismatch", int'(a), 0); bus_stop();
      bus_start(); send_byte(8'hA8, a); chk("R4 ce mismatch", int'(a), 0); bus_stop();

      // R4 R5 R6 R7 write three bytes at 0x1234
      bus_start();
      send_byte(8'hAA, a); chk("R4 select ack", int'(a), 1);
      send_byte(8'h12, a); chk("R5 addr hi ack", int'(a), 1);
      send_byte(8'h34, a); chk("R5 addr lo ack", int'(a), 1);
      wr_data(16'h1234, 8'hA5, "R6 data ack 0");
      wr_data(16'h1235, 8'h3C, "R6 data ack 1");
      wr_data(16'h1236, 8'h7E, "R6 data ack 2");
      bus_stop(); w(10);
      chk("R7 one commit after write", n_commit, 1);
      chk("R6 all strobes seen", exp_q.size(), 0);

      // R3 R8 R9 random read through repeated START
      bus_start();
      send_byte(8'hAA, a); send_byte(8'h12, a); send_byte(8'h34, a);
      bus_start();
      send_byte(8'hAB, a); chk("R3 select after repeated START", int'(a), 1);
      read_byte(1'b1, d); chk("R8 read byte 0", int'(d), 8'hA5);
      read_byte(1'b1, d); chk("R9 read after ack", int'(d), 8'h3C);
      read_byte(1'b0, d); chk("R9 read last", int'(d), 8'h7E);
      bus_stop(); w(10);
      chk("R7 no commit without data", n_commit, 1);

      // R9 NoAck leaves the address unchanged
      bus_start(); send_byte(8'hAB, a);
      read_byte(1'b0, d); chk("R9 no increment on NoAck", int'(d), 8'h7E);
      bus_stop();
      // R9 standby: no START, no answer
      send_byte(8'hAA, a); chk("R9 standby after STOP", int'(a), 0);
      bus_stop(); w(10);

      // R3 repeated START abandons the pending commit
      bus_start();
      send_byte(8'hAA, a); send_byte(8'h00, a); send_byte(8'h10, a);
      wr_data(16'h0010, 8'h55, "R6 data ack 3");
      bus_start(); send_byte(8'hAB, a);
      read_byte(1'b0, d); chk("R3 read at advanced addr", int'(d), 8'hFF);
      bus_stop(); w(10);
      chk("R3 no commit after repeated START", n_commit, 1);

      // R4 new strap value
      ce = 3'b010;
      bus_start(); send_byte(8'hAA, a); chk("R4 old straps ignored", int'(a), 0); bus_stop();
      bus_start();
      send_byte(8'hA4, a); chk("R4 new straps ack", int'(a), 1);
      send_byte(8'h00, a); send_byte(8'h10, a);
      bus_start(); send_byte(8'hA5, a);
      read_byte(1'b0, d); chk("R8 read back 0x0010", int'(d), 8'h55);
      bus_stop();

      // R6 address carry across the low byte
      bus_start();
      send_byte(8'hA4, a); send_byte(8'h12, a); send_byte(8'hFF, a);
      wr_data(16'h12FF, 8'h11, "R6 data ack 4");
      wr_data(16'h1300, 8'h22, "R6 data carry");
      bus_stop(); w(10);
      chk("R7 second commit", n_commit, 2);
      chk("R6 carry strobes seen", exp_q.size(), 0);
      chk("R1 line released at end", int'(sda_oe), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule